// File: doc/BRIEF.md
# UART Register Front End with FIFO Watermark Interrupts

This block sits between a 32-bit register bus and a separate serial line engine. Software writes bytes into an 8-entry transmit FIFO that feeds the line engine. It reads bytes from an 8-entry receive FIFO that the line engine fills. Each FIFO meets the line engine through a byte-wide valid/ready handshake. The block also holds the transmit and receive control fields, the clock divisor, and the interrupt enable mask, and it passes the stop-bit choice, the receive enable and the divisor to the line engine.

There is a single level-sensitive interrupt, and it comes only from fill-level watermarks. The transmit condition asks for more data while the transmit FIFO holds fewer bytes than a programmed count. The receive condition asks for service while the receive FIFO holds more bytes than a programmed count. Software finds the FIFO state through bit 31 of the two data registers: a transmit-data read reports "full", and a receive-data read reports "nothing was there".

The bus is word-addressed. `addr_i` is the register index, which is the byte offset divided by four. The index map is: 0 transmit data, 1 receive data, 2 transmit control, 3 receive control, 4 interrupt enable, 5 interrupt pending, 6 divisor. A read returns `rdata_o` combinationally in the cycle in which `req_i` is high. Writes and receive pops take effect at the clock edge that closes that cycle.

Top module: `uart_wm_regs`

## Requirements
- R1: After reset both FIFOs are empty, the transmit and receive enables, the interrupt enable and both watermark counts are zero, interrupt-pending reads 0, `irq_o` is low, and `tx_valid_o` and `rx_ready_o` are low.
- R2: A write to index 0 pushes `wdata_i[7:0]` into the transmit FIFO. The line engine sees the bytes on `tx_data_o` in write order, and one byte is popped for each cycle in which `tx_valid_o` and `tx_ready_i` are both high.
- R3: A read of index 0 returns bit 31 set exactly when the transmit FIFO holds 8 bytes, with all other bits zero. A write to index 0 while the FIFO is full is dropped.
- R4: A read of index 1 with data waiting pops the oldest byte and returns it in bits [7:0], with bit 31 clear and bits [30:8] zero.
- R5: A read of index 1 with the receive FIFO empty returns bit 31 set and leaves the FIFO unchanged.
- R6: Transmit control (index 2) holds the enable in bit 0, the stop-bit select in bit 1 (0 for one stop bit, 1 for two, output on `tx_stop2_o`) and a 3-bit watermark count in bits [18:16]. It reads back as written in those fields and zero elsewhere. `tx_valid_o` stays low while the enable is clear.
- R7: Receive control (index 3) holds the enable in bit 0 (output on `rx_en_o`) and a 3-bit watermark count in bits [18:16]. `rx_ready_o` is high only while the enable is set and the receive FIFO holds fewer than 8 bytes, and a byte offered while it is low is discarded.
- R8: Pending bit 0 (transmit watermark) is set while the transmit FIFO holds fewer bytes than the transmit count. With a count of 1 this means exactly when the FIFO is empty, and with a count of 0 it is never set.
- R9: Pending bit 1 (receive watermark) is set while the receive FIFO holds more bytes than the receive count. With a count of 0 this means whenever a byte is waiting.
- R10: Interrupt enable (index 4) uses bit 0 for transmit and bit 1 for receive. `irq_o` is the OR of the pending bits masked by the enable bits.
- R11: The divisor (index 6) is 16 bits in [15:0]. It reads back with the upper bits zero and drives `div_o`.
- R12: Interrupt pending (index 5) is read-only, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access this cycle |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 3 | Register index (byte offset / 4) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| tx_data_o | output | 8 | Byte offered to the line engine |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_ready_i | input | 1 | Line engine takes the byte |
| rx_data_i | input | 8 | Byte from the line engine |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_ready_o | output | 1 | Receive FIFO accepts a byte |
| tx_stop2_o | output | 1 | Two stop bits selected |
| rx_en_o | output | 1 | Receive enable |
| div_o | output | 16 | Clock divisor |
| irq_o | output | 1 | Level interrupt |

## Verification
Read data is due in the same cycle as the request, so the bench samples `rdata_o` 1 ns after it drives the request, which is before the closing edge. Every other result is registered once: pushes, pops, control writes and the pending and interrupt levels that follow from them change at the next rising edge. The bench drives on falling edges and checks at the following falling edge, where a cycle-level model of both FIFOs predicts `tx_valid_o`, `tx_data_o`, `rx_ready_o` and `irq_o`. The watermark boundaries (counts 0, 1 and 7 with full and empty FIFOs), overflow, and popping an empty FIFO are driven directly.

// File: rtl/uart_wm_pkg.sv
package uart_wm_pkg;
  localparam int unsigned BUS_W    = 32;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned IDX_W    = 3;
  localparam int unsigned FLAG_BIT = 31;
  localparam int unsigned WM_LSB   = 16;

  typedef enum logic [IDX_W-1:0] {
    IDX_TXDATA = 3'd0,
    IDX_RXDATA = 3'd1,
    IDX_TXCTRL = 3'd2,
    IDX_RXCTRL = 3'd3,
    IDX_IE     = 3'd4,
    IDX_IP     = 3'd5,
    IDX_DIV    = 3'd6
  } reg_idx_e;

  localparam int unsigned IRQ_TX = 0;
  localparam int unsigned IRQ_RX = 1;
endpackage

// File: rtl/uart_wm_fifo.sv
module uart_wm_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             pop_i,
  output logic [W-1:0]     rdata_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  assign full_o  = (cnt_q == FULL_CNT);
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wptr_q] <= wdata_i;
        wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      end
      if (do_pop) rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT);
  assert_full_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> full_o);
  assert_empty_pop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> empty_o);
endmodule

// File: rtl/uart_wm_irq.sv
module uart_wm_irq #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned WM_W  = 3
) (
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [WM_W-1:0]  tx_wm_i,
  input  logic [WM_W-1:0]  rx_wm_i,
  input  logic [1:0]       ie_i,
  output logic [1:0]       ip_o,
  output logic             irq_o
);
  import uart_wm_pkg::*;
  logic [CNT_W:0] tx_lvl, rx_lvl, tx_th, rx_th;

  // widen both sides so any CNT_W/WM_W pairing compares cleanly
  assign tx_lvl = (CNT_W+1)'(tx_count_i);
  assign rx_lvl = (CNT_W+1)'(rx_count_i);
  assign tx_th  = (CNT_W+1)'(tx_wm_i);
  assign rx_th  = (CNT_W+1)'(rx_wm_i);

  always_comb begin
    ip_o = '0;
    ip_o[IRQ_TX] = tx_lvl < tx_th;
    ip_o[IRQ_RX] = rx_lvl > rx_th;
  end

  assign irq_o = |(ip_o & ie_i);
endmodule

// File: rtl/uart_wm_regs.sv
module uart_wm_regs #(
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned WM_W       = 3,
  parameter int unsigned DIV_W      = 16,
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  output logic              tx_stop2_o,
  output logic              rx_en_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              irq_o
);
  import uart_wm_pkg::*;

  logic             tx_en_q, tx_stop2_q, rx_en_q;
  logic [WM_W-1:0]  tx_wm_q, rx_wm_q;
  logic [1:0]       ie_q, ip;
  logic [DIV_W-1:0] div_q;

  logic             wr, rd;
  logic             tx_push, tx_pop, rx_push, rx_pop;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic [7:0]       rx_byte;
  logic             unused_wdata;

  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;
  assign unused_wdata = ^wdata_i;

  assign tx_push    = wr && (addr_i == IDX_TXDATA);
  assign tx_valid_o = tx_en_q && !tx_empty;
  assign tx_pop     = tx_valid_o && tx_ready_i;
  assign rx_ready_o = rx_en_q && !rx_full;
  assign rx_push    = rx_valid_i && rx_ready_o;
  assign rx_pop     = rd && (addr_i == IDX_RXDATA);

  uart_wm_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(tx_push), .wdata_i(wdata_i[7:0]),
    .pop_i(tx_pop), .rdata_o(tx_data_o),
    .count_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty)
  );

  uart_wm_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(rx_push), .wdata_i(rx_data_i),
    .pop_i(rx_pop), .rdata_o(rx_byte),
    .count_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty)
  );

  uart_wm_irq #(.CNT_W(CNT_W), .WM_W(WM_W)) u_irq (
    .tx_count_i(tx_cnt), .rx_count_i(rx_cnt),
    .tx_wm_i(tx_wm_q), .rx_wm_i(rx_wm_q),
    .ie_i(ie_q), .ip_o(ip), .irq_o(irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_q    <= 1'b0;
      tx_stop2_q <= 1'b0;
      tx_wm_q    <= '0;
      rx_en_q    <= 1'b0;
      rx_wm_q    <= '0;
      ie_q       <= '0;
      div_q      <= '0;
    end else if (wr) begin
      unique case (addr_i)
        IDX_TXCTRL: begin
          tx_en_q    <= wdata_i[0];
          tx_stop2_q <= wdata_i[1];
          tx_wm_q    <= wdata_i[WM_LSB +: WM_W];
        end
        IDX_RXCTRL: begin
          rx_en_q <= wdata_i[0];
          rx_wm_q <= wdata_i[WM_LSB +: WM_W];
        end
        IDX_IE:  ie_q  <= wdata_i[1:0];
        IDX_DIV: div_q <= wdata_i[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      IDX_TXDATA: rdata_o[FLAG_BIT] = tx_full;
      IDX_RXDATA: begin
        rdata_o[FLAG_BIT] = rx_empty;
        rdata_o[7:0]      = rx_empty ? 8'h00 : rx_byte;
      end
      IDX_TXCTRL: begin
        rdata_o[0] = tx_en_q;
        rdata_o[1] = tx_stop2_q;
        rdata_o[WM_LSB +: WM_W] = tx_wm_q;
      end
      IDX_RXCTRL: begin
        rdata_o[0] = rx_en_q;
        rdata_o[WM_LSB +: WM_W] = rx_wm_q;
      end
      IDX_IE:  rdata_o[1:0] = ie_q;
      IDX_IP:  rdata_o[1:0] = ip;
      IDX_DIV: rdata_o[DIV_W-1:0] = div_q;
      default: ;
    endcase
  end

  assign tx_stop2_o = tx_stop2_q;
  assign rx_en_o    = rx_en_q;
  assign div_o      = div_q;

  assert_tx_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_q |-> !tx_valid_o);
  assert_rx_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |-> (rx_en_q && !rx_full));
  assert_tx_wm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_empty && tx_wm_q != '0) |-> ip[IRQ_TX]);
  assert_rx_wm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_wm_q == '0 && !rx_empty) |-> ip[IRQ_RX]);
  assert_irq_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((ie_q & ip) != 2'b00));
  assert_div_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == IDX_DIV) |=> (div_o == $past(wdata_i[DIV_W-1:0])));
  assert_ip_ro_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == IDX_IP) |=> $stable(ie_q));
endmodule

// File: tb/uart_wm_regs_bench.sv
`timescale 1ns/1ps
module uart_wm_regs_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [7:0]  tx_data_o;
  logic        tx_valid_o;
  logic        tx_ready_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        rx_valid_i = 1'b0;
  logic        rx_ready_o, tx_stop2_o, rx_en_o, irq_o;
  logic [15:0] div_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk_i = ~clk_i;

  uart_wm_regs u_uart_wm_regs (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  function automatic logic [31:0] ctrl_word(input bit en, input bit stop2, input logic [2:0] wm);
    return {13'd0, wm, 14'd0, stop2, en};
  endfunction

  function automatic bit exp_irq(input int txn, input int rxn, input int txwm, input int rxwm, input logic [1:0] ie);
    return (ie[0] && (txn < txwm)) || (ie[1] && (rxn > rxwm));
  endfunction

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  got [$];
    logic [7:0]  txq [$];
    logic [7:0]  rxq [$];
    int txwm, rxwm;
    process::self().srandom(32'd1234);

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    bus_rd(3'd5, d); chk(d == 0, "R1 ip", d, 0);
    bus_rd(3'd2, d); chk(d == 0, "R1 txctrl", d, 0);
    bus_rd(3'd3, d); chk(d == 0, "R1 rxctrl", d, 0);
    bus_rd(3'd4, d); chk(d == 0, "R1 ie", d, 0);
    bus_rd(3'd0, d); chk(d == 0, "R1 txdata not full", d, 0);
    chk(!irq_o && !tx_valid_o && !rx_ready_o, "R1 outputs low",
        {29'd0, irq_o, tx_valid_o, rx_ready_o}, 0);

    // R6 control fields, transmit disabled
    bus_wr(3'd2, 32'hFFF8_FFFC | ctrl_word(0, 1, 3'd1));
    bus_rd(3'd2, d); chk(d == ctrl_word(0, 1, 3'd1), "R6 txctrl readback", d, ctrl_word(0, 1, 3'd1));
    chk(tx_stop2_o == 1'b1, "R6 stop2 out", tx_stop2_o, 1);
    // R8 empty with count 1 -> pending
    bus_rd(3'd5, d); chk(d == 1, "R8 tx wm pending", d, 1);
    chk(irq_o == 0, "R10 masked", irq_o, 0);
    bus_wr(3'd4, 32'h1);
    chk(irq_o == 1, "R10 tx enabled irq", irq_o, 1);

    for (int i = 0; i < 9; i++) begin
      bus_wr(3'd0, 32'hFFFF_FF00 | (32'hA0 + i));
      if (i == 0) chk(irq_o == 0, "R8 one byte clears", irq_o, 0);
    end
    bus_rd(3'd0, d); chk(d == 32'h8000_0000, "R3 full flag", d, 32'h8000_0000);
    chk(tx_valid_o == 0, "R6 disabled no valid", tx_valid_o, 0);

    bus_wr(3'd2, ctrl_word(1, 0, 3'd1));
    chk(tx_stop2_o == 0, "R6 stop1", tx_stop2_o, 0);
    tx_ready_i = 1'b1;
    for (int c = 0; c < 12; c++) begin
      #1 if (tx_valid_o) got.push_back(tx_data_o);
      @(negedge clk_i);
    end
    tx_ready_i = 1'b0;
    chk(got.size() == 8, "R3 ninth dropped", got.size(), 8);
    for (int i = 0; i < 8 && i < got.size(); i++)
      chk(got[i] == 8'hA0 + i, "R2 order", got[i], 8'hA0 + i);
    chk(irq_o == 1, "R8 drained pending", irq_o, 1);

    // R8 count 0 never pending
    bus_wr(3'd2, ctrl_word(1, 0, 3'd0));
    bus_rd(3'd5, d); chk(d[0] == 0, "R8 count0 never", d, 0);

    // R11 divisor
    bus_wr(3'd6, 32'hFFFF_ABCD);
    bus_rd(3'd6, d); chk(d == 32'h0000_ABCD, "R11 div readback", d, 32'hABCD);
    chk(div_o == 16'hABCD, "R11 div_o", div_o, 16'hABCD);

    // R12 pending is read-only
    bus_wr(3'd5, 32'h3);
    bus_rd(3'd5, d); chk(d == 0, "R12 ip unchanged", d, 0);
    bus_rd(3'd4, d); chk(d == 1, "R12 ie unchanged", d, 1);

    // R5 empty pop
    bus_rd(3'd1, d); chk(d[31] == 1, "R5 empty flag", d, 32'h8000_0000);

    // R7 disabled receive discards
    rx_valid_i = 1'b1; rx_data_i = 8'h55;
    #1 chk(rx_ready_o == 0, "R7 not ready disabled", rx_ready_o, 0);
    @(negedge clk_i); rx_valid_i = 1'b0;
    bus_rd(3'd1, d); chk(d[31] == 1, "R7 discarded", d, 32'h8000_0000);

    bus_wr(3'd3, ctrl_word(1, 0, 3'd0));
    bus_rd(3'd3, d); chk(d == 32'h1, "R7 rxctrl readback", d, 1);
    chk(rx_en_o == 1 && rx_ready_o == 1, "R7 enabled", {rx_en_o, rx_ready_o}, 2'b11);
    for (int i = 0; i < 9; i++) begin
      rx_valid_i = 1'b1; rx_data_i = (i == 8) ? 8'h99 : 8'h11 + i;
      @(negedge clk_i);
    end
    rx_valid_i = 1'b0;
    chk(rx_ready_o == 0, "R7 full not ready", rx_ready_o, 0);
    bus_rd(3'd5, d); chk(d[1] == 1, "R9 count0 pending", d, 2);
    bus_wr(3'd3, ctrl_word(1, 0, 3'd7));
    bus_rd(3'd5, d); chk(d[1] == 1, "R9 8>7 pending", d, 2);
    bus_wr(3'd4, 32'h2);
    chk(irq_o == 1, "R10 rx irq", irq_o, 1);
    bus_rd(3'd1, d); chk(d == 32'h11, "R4 first pop", d, 32'h11);
    chk(irq_o == 0, "R9 7 not >7", irq_o, 0);
    for (int i = 1; i < 8; i++) begin
      bus_rd(3'd1, d); chk(d == 32'h11 + i, "R4 pop order", d, 32'h11 + i);
    end
    bus_rd(3'd1, d); chk(d[31] == 1, "R5 empty after drain", d, 32'h8000_0000);
    rx_valid_i = 1'b1; rx_data_i = 8'h3C;
    @(negedge clk_i); rx_valid_i = 1'b0;
    bus_rd(3'd1, d); chk(d == 32'h3C, "R5 pointers intact", d, 32'h3C);

    // random mixed traffic against a queue model
    txwm = $urandom_range(0, 7);
    rxwm = $urandom_range(0, 7);
    bus_wr(3'd2, ctrl_word(1, 1, 3'(txwm)));
    bus_wr(3'd3, ctrl_word(1, 0, 3'(rxwm)));
    bus_wr(3'd4, 32'h3);
    for (int c = 0; c < 3000; c++) begin
      int op;
      bit tpop, tpush, rpush, rpop;
      logic [7:0] wb;
      op = $urandom_range(0, 4);
      wb = 8'($urandom);
      tx_ready_i = ($urandom_range(0, 2) == 0);
      rx_valid_i = ($urandom_range(0, 2) == 0);
      rx_data_i  = 8'($urandom);
      req_i = (op != 0); we_i = (op == 1);
      addr_i = (op == 1 || op == 3) ? 3'd0 : 3'd1;
      wdata_i = {24'd0, wb};
      #1;
      chk(tx_valid_o == (txq.size() > 0), "R2 tx valid", tx_valid_o, txq.size() > 0);
      if (txq.size() > 0) chk(tx_data_o == txq[0], "R2 tx data", tx_data_o, txq[0]);
      chk(rx_ready_o == (rxq.size() < 8), "R7 rx ready", rx_ready_o, rxq.size() < 8);
      chk(irq_o == exp_irq(txq.size(), rxq.size(), txwm, rxwm, 2'b11), "R10 irq",
          irq_o, exp_irq(txq.size(), rxq.size(), txwm, rxwm, 2'b11));
      if (op == 3) chk(rdata_o == {txq.size() == 8, 31'd0}, "R3 full flag", rdata_o, {txq.size() == 8, 31'd0});
      if (op == 2 || op == 4) begin
        if (rxq.size() > 0) chk(rdata_o == {24'd0, rxq[0]}, "R4 pop data", rdata_o, {24'd0, rxq[0]});
        else chk(rdata_o[31] == 1, "R5 empty read", rdata_o, 32'h8000_0000);
      end
      tpop  = (txq.size() > 0) && tx_ready_i;
      tpush = (op == 1) && (txq.size() < 8);
      rpush = rx_valid_i && (rxq.size() < 8);
      rpop  = (op == 2 || op == 4) && (rxq.size() > 0);
      if (tpop) void'(txq.pop_front());
      if (tpush) txq.push_back(wb);
      if (rpop) void'(rxq.pop_front());
      if (rpush) rxq.push_back(rx_data_i);
      @(negedge clk_i);
    end
    req_i = 1'b0; we_i = 1'b0; rx_valid_i = 1'b0; tx_ready_i = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule